// File: doc/BRIEF.md
# Oversampled SPI Register Slave

This block is a serial slave port that runs entirely on a fast core clock. The serial clock, data input and active-low select come from an external master and may be asynchronous to that clock. The block samples them through synchronizers and detects serial clock edges by comparing successive samples. Each datagram is a fixed 32-bit word, shifted in MSB first.

When the select is released, a word of exactly 32 bits is copied into a buffer register, and a one-cycle strobe is raised with it. A small register bank then decodes the buffered word. Bit 31 set means write. Bits 30:24 give the register address. Bits 23:0 carry the data.

Reply data is loaded into an output shift register when the select falls and is shifted out during the same exchange. The reply reports the register addressed by the previous valid datagram. Register 0 holds a 4-bit clock-prescaler field in bits 3:0 that resets to 15. Every other bit resets to zero.

Top module: `spi_reg_slave`

## Requirements
- R1: The select falling edge clears the bit count. Each detected SCK rising edge while selected shifts `sdi_i` into the receive word, MSB first. When the select rises after exactly 32 bits, `frame_o` takes the received word.
- R2: `frame_stb_o` is high for exactly one core cycle per valid frame. It appears in the cycle after the third core clock edge following the select pin rising, together with the new `frame_o`.
- R3: A frame that ends with a bit count other than 32 (short or long) raises no strobe. It leaves `frame_o` and every register unchanged.
- R4: A valid frame with bit 31 set writes bits 23:0 into the register addressed by bits 30:24, one core edge after the strobe. An address of NUM_REGS or above changes no register. A frame with bit 31 clear writes nothing.
- R5: The reply is loaded when the select falls. It is 32 bits: bit 31 zero, bits 30:24 the address of the last valid frame, and bits 23:0 that register's contents, or zero if the address is out of range. The reply leaves on `sdo_o` MSB first, moving one bit per detected SCK falling edge.
- R6: Each new reply bit is on `sdo_o` no later than three core clock edges after the SCK pin falls, or after the select pin falls for the first bit.
- R7: While the select has been high for more than three core cycles, `sdo_oe_o` and `sdo_o` are both 0.
- R8: After reset, register 0 is 0x00000F, all other registers are zero, `frame_o` is zero, and the reply address is 0.
- R9: While `rst_ni` is low, serial pin activity raises no strobe and changes no register.
- R10: SCK low and high phases of three core cycles are handled with correct data in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master, asynchronous |
| sdi_i | input | 1 | Serial data from master, asynchronous |
| csn_i | input | 1 | Active-low select from master, asynchronous |
| sdo_o | output | 1 | Serial reply data, 0 when not driving |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| frame_o | output | 32 | Buffer holding the last valid datagram |
| frame_stb_o | output | 1 | One-cycle strobe on buffer update |
| regs_o | output | NUM_REGS*24 | Register bank contents, register 0 in the low bits |

## Verification
The hardest case to reach from the ports is the minimum serial phase of three core cycles. At that phase the reply bit must already have been shifted, through two synchronizer stages and an edge-detect register, when the master samples it. The stimulus task takes the half period as an argument. It runs datagrams at three, four and eight core cycles, and at every SCK rise it checks `sdo_o` against the reply predicted from the model's registers. Frames of 31 and 33 bits, an out-of-range address, and a reset asserted during serial activity cover the discard paths.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  parameter int FRAME_W   = 32;
  parameter int DATA_W    = 24;
  parameter int ADDR_W    = 7;
  parameter int ADDR_LSB  = DATA_W;
  parameter int WR_BIT    = FRAME_W - 1;
  parameter int PRESC_W   = 4;
  parameter int PRESC_RST = 15;
  parameter int CNT_W     = $clog2(FRAME_W) + 1;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [ADDR_W-1:0]  addr_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame import spi_reg_pkg::*; (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sck_s_i,
  input  logic   sdi_s_i,
  input  logic   csn_s_i,
  input  frame_t reply_i,
  output logic   sdo_o,
  output logic   sdo_oe_o,
  output frame_t frame_o,
  output logic   frame_stb_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic             sck_d_q, csn_d_q;
  logic [CNT_W-1:0] bit_cnt_q;
  frame_t           rx_q, tx_q, buf_q;
  logic             oe_q, stb_q;
  logic             sck_rise, sck_fall, cs_fall, cs_rise, cs_act;

  assign sck_rise = sck_s_i & ~sck_d_q;
  assign sck_fall = ~sck_s_i & sck_d_q;
  assign cs_fall  = csn_d_q & ~csn_s_i;
  assign cs_rise  = ~csn_d_q & csn_s_i;
  assign cs_act   = ~csn_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      csn_d_q <= 1'b1;
    end else begin
      sck_d_q <= sck_s_i;
      csn_d_q <= csn_s_i;
    end
  end

  // receive path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      bit_cnt_q <= '0;
    end else if (cs_fall) begin
      bit_cnt_q <= '0;
    end else if (cs_act && sck_rise) begin
      rx_q <= {rx_q[FRAME_W-2:0], sdi_s_i};
      if (bit_cnt_q != '1) bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  // transmit path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      oe_q <= 1'b0;
    end else begin
      oe_q <= cs_act;
      if (cs_fall)                tx_q <= reply_i;
      else if (cs_act && sck_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  // frame buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= cs_rise && (bit_cnt_q == FULL_CNT);
      if (cs_rise && (bit_cnt_q == FULL_CNT)) buf_q <= rx_q;
    end
  end

  assign sdo_o       = oe_q & tx_q[FRAME_W-1];
  assign sdo_oe_o    = oe_q;
  assign frame_o     = buf_q;
  assign frame_stb_o = stb_q;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> bit_cnt_q == '0); // R1
  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q); // R2
  AST_STB_FULL_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> $past(bit_cnt_q) == FULL_CNT); // R3
  AST_BUF_ONLY_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(buf_q) |-> stb_q); // R3
  AST_SDO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_s_i && csn_d_q) |=> !sdo_o && !sdo_oe_o); // R7
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank import spi_reg_pkg::*; #(
  parameter int NUM_REGS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stb_i,
  input  frame_t                   frame_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output frame_t                   reply_o
);
  localparam int    IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam addr_t NUM_A  = ADDR_W'(NUM_REGS);

  data_t regs_q [NUM_REGS];
  addr_t last_addr_q;
  addr_t wr_addr;
  data_t wr_data, rd_data;
  logic  wr_en;

  assign wr_en   = frame_i[WR_BIT];
  assign wr_addr = frame_i[ADDR_LSB +: ADDR_W];
  assign wr_data = frame_i[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_addr_q <= '0;
    else if (stb_i) last_addr_q <= wr_addr;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam data_t RST_VAL = (g == 0) ? DATA_W'(PRESC_RST) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= RST_VAL;
      else if (stb_i && wr_en && (wr_addr == ADDR_W'(g)))
        regs_q[g] <= wr_data;
    end
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];

    AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(stb_i && wr_en && (wr_addr == ADDR_W'(g))) |=> $stable(regs_q[g])); // R4
  end

  assign rd_data = (last_addr_q < NUM_A) ? regs_q[last_addr_q[IDX_W-1:0]] : '0;
  assign reply_o = {1'b0, last_addr_q, rd_data};

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(last_addr_q)); // R5
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave import spi_reg_pkg::*; #(
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sck_i,
  input  logic                       sdi_i,
  input  logic                       csn_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic [FRAME_W-1:0]         frame_o,
  output logic                       frame_stb_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [2:0] pins_s;
  frame_t     reply;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sdi_i, sck_i}),
    .q_o   (pins_s)
  );

  spi_frame i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (pins_s[0]),
    .sdi_s_i    (pins_s[1]),
    .csn_s_i    (pins_s[2]),
    .reply_i    (reply),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .frame_o    (frame_o),
    .frame_stb_o(frame_stb_o)
  );

  spi_regbank #(.NUM_REGS(NUM_REGS)) i_regbank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (frame_stb_o),
    .frame_i(frame_o),
    .regs_o (regs_o),
    .reply_o(reply)
  );
endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;

  logic clk = 0, rst_ni = 0, sck = 0, sdi = 0, csn = 1;
  logic sdo, sdo_oe, stb;
  logic [31:0] frame;
  logic [NR*24-1:0] regs;

  spi_reg_slave i_spi_reg_slave (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .frame_o(frame), .frame_stb_o(stb),
    .regs_o(regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0, n_stb = 0, cs_hi = 0;
  int stb_due = -1;
  logic [31:0] p_word, m_frame;
  logic [23:0] m_regs [NR];
  logic [6:0]  m_last;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string msg);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [NR*24-1:0] m_pack();
    logic [NR*24-1:0] v;
    for (int i = 0; i < NR; i++) v[i*24 +: 24] = m_regs[i];
    return v;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NR; i++) m_regs[i] = '0;
    m_regs[0] = 24'h00000F;
    m_last = '0; m_frame = '0; stb_due = -1;
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_ni && cyc == stb_due) m_frame = p_word;
    if (rst_ni && cyc == stb_due + 1) begin
      if (p_word[31] && p_word[30:24] < NR) m_regs[p_word[25:24]] = p_word[23:0];
      m_last = p_word[30:24];
    end
    if (stb) n_stb++;
    cs_hi = csn ? cs_hi + 1 : 0;
    chk(stb == (rst_ni && cyc == stb_due),
        $sformatf("R2 stb act=%0b exp=%0b cyc=%0d", stb, rst_ni && cyc == stb_due, cyc));
    chk(frame == m_frame, $sformatf("R1 frame act=%h exp=%h", frame, m_frame));
    chk(regs == m_pack(), $sformatf("R4 regs act=%h exp=%h", regs, m_pack()));
    if (cs_hi > 4)
      chk(!sdo && !sdo_oe, $sformatf("R7 idle sdo=%0b oe=%0b exp=0 0", sdo, sdo_oe));
  end

  task automatic xfer(input logic [31:0] w, input int nbits, input int h);
    logic [31:0] rep;
    rep = {1'b0, m_last, (m_last < NR) ? m_regs[m_last[1:0]] : 24'h0};
    csn = 0; sdi = w[31];
    repeat (h) @(negedge clk);
    chk(sdo_oe, $sformatf("R7 oe act=%0b exp=1", sdo_oe));
    for (int i = 0; i < nbits; i++) begin
      chk(sdo == ((i < 32) ? rep[31-i] : 1'b0),
          $sformatf("R5 R6 sdo bit%0d h=%0d act=%0b exp=%0b", i, h, sdo,
                    (i < 32) ? rep[31-i] : 1'b0));
      sck = 1;
      repeat (h) @(negedge clk);
      sck = 0;
      sdi = (i < 31) ? w[30-i] : 1'b0;
      repeat (h) @(negedge clk);
    end
    csn = 1;
    if (nbits == 32) begin
      p_word = w;
      stb_due = cyc + 3;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst_ni = 0; m_reset();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int s0;
    m_reset();
    repeat (4) @(negedge clk);
    // R9: pin activity during reset
    for (int i = 0; i < 6; i++) begin
      csn = ~csn; sck = ~sck; sdi = i[0];
      repeat (3) @(negedge clk);
    end
    csn = 1; sck = 0;
    repeat (4) @(negedge clk);
    chk(n_stb == 0, $sformatf("R9 stb during reset act=%0d exp=0", n_stb));
    @(posedge clk); #2 rst_ni = 1;
    repeat (6) @(negedge clk);
    chk(regs[23:0] == 24'h00000F, $sformatf("R8 reg0 act=%h exp=00000f", regs[23:0]));
    chk(regs[NR*24-1:24] == '0, $sformatf("R8 upper regs act=%h exp=0", regs[NR*24-1:24]));

    xfer(32'h0000_0000, 32, 4);                 // read reg0, reply shows reset value
    xfer(32'h81AB_CDE1, 32, 3);                 // R10 minimum phase write reg1
    xfer(32'h8212_3456, 32, 8);
    xfer(32'h83FF_FFFF, 32, 3);
    xfer(32'h8955_5555, 32, 4);                 // R4 out-of-range write
    xfer(32'h0100_0000, 32, 3);                 // reply: addr 9 -> data 0
    xfer(32'h0300_0000, 32, 4);                 // reply: reg1
    xfer(32'h0000_0000, 32, 3);                 // reply: reg3
    chk(regs[47:24] == 24'hABCDE1, $sformatf("R4 reg1 act=%h exp=abcde1", regs[47:24]));

    s0 = n_stb;
    xfer(32'h80AA_AAAA, 31, 3);                 // R3 short
    xfer(32'h80BB_BBBB, 33, 4);                 // R3 long
    chk(n_stb == s0, $sformatf("R3 discarded stb act=%0d exp=%0d", n_stb, s0));
    chk(regs[23:0] == 24'h00000F, $sformatf("R3 reg0 act=%h exp=00000f", regs[23:0]));

    xfer(32'h8000_0003, 32, 3);                 // prescaler field write
    xfer(32'h0000_0000, 32, 4);
    chk(n_stb == s0 + 2, $sformatf("R2 strobe count act=%0d exp=%0d", n_stb, s0 + 2));

    do_reset();
    for (int i = 0; i < 8; i++) begin
      csn = i[1]; sck = i[0]; sdi = ~i[0];
      repeat (3) @(negedge clk);
    end
    csn = 1; sck = 0;
    repeat (4) @(negedge clk);
    chk(regs == m_pack(), $sformatf("R9 regs in reset act=%h exp=%h", regs, m_pack()));
    @(posedge clk); #2 rst_ni = 1;
    repeat (6) @(negedge clk);
    xfer(32'h0000_0000, 32, 3);                 // R8 reply after reset
    repeat (10) @(negedge clk);
    summary();
  end
endmodule